// File: doc/BRIEF.md
# Time-Triggered Dual-Polarization Capture Buffer

This block records raw dual-polarization samples into a linear memory at a scheduled time, then lets a processor read the recording back slowly. A seconds counter advances on each once-per-second pulse. Once armed, the block waits until that counter equals a programmed trigger second. It then writes one packed word per clock to consecutive addresses, and stops by itself when the memory holds its full depth of words.

After capture the block sits in a full state until software starts the readout. During readout it prefetches one word at a time from the memory into a holding register. Each read of the data register consumes the held word and starts the next fetch. When every word has been consumed the block returns to idle. Arming is refused until that point, unless software issues a clear.

The sample source can be the live converter inputs or a built-in counter pattern, which makes a readout checkable word by word. If the memory drops its ready signal during capture, that sample is lost. A sticky overflow flag is then set, and the word count at the first loss is kept.

Top module: `trig_capture`

## Requirements
- R1: After reset the state code is IDLE (0), the status register reads 0 and mem_req_o is low.
- R2: The seconds counter (register 2) increases by one for each clock with pps_i high, holds otherwise, and is loaded by a write to register 2.
- R3: Writing control bit 0 (arm) in IDLE enters ARMED (1). mem_req_o rises one clock after the edge at which the seconds counter becomes equal to the trigger (register 1), with the state CAPTURING (2).
- R4: In CAPTURING, one write is issued per clock to addresses 0, 1, 2 and so on. After exactly 2^AW accepted writes the state is FULL (3), no further request is made, and the status word count (bits 31:16) equals 2^AW.
- R5: A stored word holds X in bits SW-1:0 and Y in bits 2*SW-1:SW.
- R6: Control bit 2 latched at arm selects the test pattern. The word offered on capture cycle n carries X = n mod 2^SW and Y = (n + 2^(SW-1)) mod 2^SW. Otherwise the word carries the converter inputs registered once.
- R7: A capture cycle with mem_rdy_i low drops that sample and sets the sticky overflow flag (status bit 3). Register 5 then holds the word count at the first loss.
- R8: Control bit 3 in FULL enters READOUT (4). Each read of register 4 returns bit 31 = word available and the word in the low bits, in address order. The state returns to IDLE after the last word is consumed.
- R9: Control bit 1 (clear) returns the block to IDLE from any state, with the overflow flag and word count reset to 0.
- R10: Arm requests in FULL or READOUT leave the state unchanged.
- R11: reg_rdata_o is loaded at the clock edge on which reg_re_i is high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | Once-per-second pulse, one clock wide |
| adc_x_i | input | SW | X polarization sample |
| adc_y_i | input | SW | Y polarization sample |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the clock after the strobe |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 2*SW | Memory write data |
| mem_rdy_i | input | 1 | Memory accepts the request this clock |
| mem_rvalid_i | input | 1 | Read data returned |
| mem_rdata_i | input | 2*SW | Read data |

## Verification
Register reads are sampled one clock after the strobe, at the falling edge that follows the loading edge. The trigger check samples mem_req_o at the falling edges just after the seconds counter matches and one clock later, so it pins down the single-clock delay. Capture results are due 2^AW accepted writes after the first request. The bench counts requests at every falling edge, and checks the state only after that window has closed. Readout words arrive after a variable memory latency, so the bench polls the available bit rather than assuming a fixed delay.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_CAPT  = 3'd2,
    ST_FULL  = 3'd3,
    ST_DRAIN = 3'd4
  } cap_state_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TRIG = 3'd1;
  localparam logic [2:0] A_SECS = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;
  localparam logic [2:0] A_LOSS = 3'd5;

  localparam int B_ARM  = 0;
  localparam int B_CLR  = 1;
  localparam int B_TPAT = 2;
  localparam int B_READ = 3;
endpackage

// File: rtl/tcap_timer.sv
module tcap_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pps_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic [TW-1:0] trig_i,
  output logic [TW-1:0] secs_o,
  output logic          hit_o
);
  logic [TW-1:0] secs_q, secs_d;
  logic          secs_en;

  always_comb begin
    secs_en = load_i | pps_i;
    secs_d  = load_i ? load_val_i : secs_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       secs_q <= '0;
    else if (secs_en) secs_q <= secs_d;
  end

  assign secs_o = secs_q;
  assign hit_o  = (secs_q == trig_i);

  p_secs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pps_i && !load_i) |=> $stable(secs_o));
endmodule

// File: rtl/tcap_source.sv
module tcap_source #(
  parameter int SW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            tpat_i,
  input  logic [SW-1:0]   adc_x_i,
  input  logic [SW-1:0]   adc_y_i,
  output logic [2*SW-1:0] word_o
);
  localparam logic [SW-1:0] HALF = SW'(1) << (SW-1);

  logic [2*SW-1:0] smp_q;
  logic [SW-1:0]   pat_q, pat_d;

  always_comb begin
    pat_d = run_i ? pat_q + SW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      pat_q <= '0;
    end else begin
      smp_q <= {adc_y_i, adc_x_i};
      pat_q <= pat_d;
    end
  end

  assign word_o = tpat_i ? {pat_q + HALF, pat_q} : smp_q;

  p_pat_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_i) && tpat_i) |-> (word_o[SW-1:0] == '0));
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          tpat_req_i,
  input  logic          hit_i,
  input  logic          pop_i,
  input  logic [DW-1:0] word_i,
  input  logic          mem_rdy_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output cap_state_t    state_o,
  output logic          tpat_o,
  output logic [AW:0]   wcnt_o,
  output logic          ovf_o,
  output logic [AW:0]   loss_o,
  output logic [DW-1:0] hold_o,
  output logic          hold_vld_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam int          CW    = AW + 1;
  localparam int          DEPTH = 1 << AW;
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);
  localparam logic [CW-1:0] ALL  = CW'(DEPTH);

  cap_state_t    st_q, st_d;
  logic [CW-1:0] wcnt_q, wcnt_d, loss_q, loss_d, rptr_q, rptr_d;
  logic          ovf_q, ovf_d, tpat_q, tpat_d, pend_q, pend_d, hvld_q, hvld_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          wr_go, rd_go;

  always_comb begin
    wr_go  = (st_q == ST_CAPT);
    rd_go  = (st_q == ST_DRAIN) && !hvld_q && !pend_q && (rptr_q != ALL);
    st_d   = st_q;
    wcnt_d = wcnt_q;
    loss_d = loss_q;
    rptr_d = rptr_q;
    ovf_d  = ovf_q;
    tpat_d = tpat_q;
    pend_d = pend_q;
    hvld_d = hvld_q;
    hold_d = hold_q;
    unique case (st_q)
      ST_IDLE: if (arm_i) begin
        st_d   = ST_ARMED;
        wcnt_d = '0;
        loss_d = '0;
        ovf_d  = 1'b0;
        rptr_d = '0;
        tpat_d = tpat_req_i;
      end
      ST_ARMED: if (hit_i) st_d = ST_CAPT;
      ST_CAPT: begin
        if (mem_rdy_i) begin
          wcnt_d = wcnt_q + CW'(1);
          if (wcnt_q == LAST) st_d = ST_FULL;
        end else begin
          ovf_d = 1'b1;
          if (!ovf_q) loss_d = wcnt_q;
        end
      end
      ST_FULL: if (start_i) begin
        st_d   = ST_DRAIN;
        rptr_d = '0;
      end
      ST_DRAIN: begin
        if (rd_go && mem_rdy_i) pend_d = 1'b1;
        if (pend_q && mem_rvalid_i) begin
          hold_d = mem_rdata_i;
          hvld_d = 1'b1;
          pend_d = 1'b0;
          rptr_d = rptr_q + CW'(1);
        end
        if (pop_i && hvld_q) begin
          hvld_d = 1'b0;
          if (rptr_q == ALL) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (clr_i) begin
      st_d   = ST_IDLE;
      wcnt_d = '0;
      loss_d = '0;
      ovf_d  = 1'b0;
      rptr_d = '0;
      pend_d = 1'b0;
      hvld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      loss_q <= '0;
      rptr_q <= '0;
      ovf_q  <= 1'b0;
      tpat_q <= 1'b0;
      pend_q <= 1'b0;
      hvld_q <= 1'b0;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      loss_q <= loss_d;
      rptr_q <= rptr_d;
      ovf_q  <= ovf_d;
      tpat_q <= tpat_d;
      pend_q <= pend_d;
      hvld_q <= hvld_d;
      hold_q <= hold_d;
    end
  end

  assign state_o     = st_q;
  assign tpat_o      = tpat_q;
  assign wcnt_o      = wcnt_q;
  assign ovf_o       = ovf_q;
  assign loss_o      = loss_q;
  assign hold_o      = hold_q;
  assign hold_vld_o  = hvld_q;
  assign mem_req_o   = wr_go || rd_go;
  assign mem_we_o    = wr_go;
  assign mem_addr_o  = wr_go ? wcnt_q[AW-1:0] : rptr_q[AW-1:0];
  assign mem_wdata_o = word_i;

  p_req_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (st_q == ST_CAPT || st_q == ST_DRAIN));
  p_full_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FULL) |-> (wcnt_q == ALL));
  p_trigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && hit_i && !clr_i) |=> (st_q == ST_CAPT));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i && !(st_q == ST_IDLE && arm_i)) |=> ovf_q);
  p_refuse_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FULL && !clr_i && !start_i) |=> (st_q == ST_FULL));
  p_hold_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hvld_q |-> (st_q == ST_DRAIN));
endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
  import tcap_pkg::*;
#(
  parameter int TW = 32,
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             arm_o,
  output logic             clr_o,
  output logic             start_o,
  output logic             tpat_req_o,
  output logic             load_o,
  output logic             pop_o,
  output logic [TW-1:0]    trig_o,
  input  logic [TW-1:0]    secs_i,
  input  cap_state_t       state_i,
  input  logic [AW:0]      wcnt_i,
  input  logic             ovf_i,
  input  logic [AW:0]      loss_i,
  input  logic [DW-1:0]    hold_i,
  input  logic             hold_vld_i
);
  logic             ctrl_wr;
  logic             trig_en;
  logic [TW-1:0]    trig_q;
  logic [REG_W-1:0] rd_d, rd_q;

  always_comb begin
    ctrl_wr    = reg_we_i && (reg_addr_i == A_CTRL);
    arm_o      = ctrl_wr && reg_wdata_i[B_ARM];
    clr_o      = ctrl_wr && reg_wdata_i[B_CLR];
    tpat_req_o = reg_wdata_i[B_TPAT];
    start_o    = ctrl_wr && reg_wdata_i[B_READ];
    load_o     = reg_we_i && (reg_addr_i == A_SECS);
    trig_en    = reg_we_i && (reg_addr_i == A_TRIG);
    pop_o      = reg_re_i && (reg_addr_i == A_DATA);
  end

  always_comb begin
    rd_d = '0;
    unique case (reg_addr_i)
      A_TRIG: rd_d[TW-1:0] = trig_q;
      A_SECS: rd_d[TW-1:0] = secs_i;
      A_STAT: begin
        rd_d[2:0]       = state_i;
        rd_d[3]         = ovf_i;
        rd_d[16 +: AW+1] = wcnt_i;
      end
      A_DATA: begin
        rd_d[DW-1:0]  = hold_i;
        rd_d[REG_W-1] = hold_vld_i;
      end
      A_LOSS: rd_d[AW:0] = loss_i;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      rd_q   <= '0;
    end else begin
      if (trig_en)  trig_q <= reg_wdata_i[TW-1:0];
      if (reg_re_i) rd_q   <= rd_d;
    end
  end

  assign trig_o      = trig_q;
  assign reg_rdata_o = rd_q;

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re_i |=> $stable(reg_rdata_o));
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import tcap_pkg::*;
#(
  parameter int AW = 10,
  parameter int SW = 12,
  parameter int TW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pps_i,
  input  logic [SW-1:0]   adc_x_i,
  input  logic [SW-1:0]   adc_y_i,
  input  logic            reg_we_i,
  input  logic            reg_re_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [2*SW-1:0] mem_wdata_o,
  input  logic            mem_rdy_i,
  input  logic            mem_rvalid_i,
  input  logic [2*SW-1:0] mem_rdata_i
);
  localparam int DW = 2 * SW;

  logic          arm, clr, start, tpat_req, load, pop, hit, tpat, ovf, hvld;
  logic [TW-1:0] trig, secs;
  logic [AW:0]   wcnt, loss;
  logic [DW-1:0] word, hold;
  cap_state_t    state;

  tcap_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .load_i(load),
    .load_val_i(reg_wdata_i[TW-1:0]), .trig_i(trig), .secs_o(secs), .hit_o(hit)
  );

  tcap_source #(.SW(SW)) u_source (
    .clk(clk), .rst_n(rst_n), .run_i(state == ST_CAPT), .tpat_i(tpat),
    .adc_x_i(adc_x_i), .adc_y_i(adc_y_i), .word_o(word)
  );

  tcap_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .clr_i(clr), .start_i(start),
    .tpat_req_i(tpat_req), .hit_i(hit), .pop_i(pop), .word_i(word),
    .mem_rdy_i(mem_rdy_i), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .state_o(state), .tpat_o(tpat), .wcnt_o(wcnt), .ovf_o(ovf), .loss_o(loss),
    .hold_o(hold), .hold_vld_o(hvld), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  tcap_regs #(.TW(TW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .arm_o(arm), .clr_o(clr), .start_o(start), .tpat_req_o(tpat_req),
    .load_o(load), .pop_o(pop), .trig_o(trig), .secs_i(secs), .state_i(state),
    .wcnt_i(wcnt), .ovf_i(ovf), .loss_i(loss), .hold_i(hold), .hold_vld_i(hvld)
  );
endmodule

// File: tb/test_trig_capture.sv
module test_trig_capture;
  localparam int AW = 4;
  localparam int SW = 12;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, pps = 1'b0;
  logic [SW-1:0] ax = '0, ay = '0;
  logic we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic req, mwe, rdy = 1'b1, rvalid;
  logic [AW-1:0] maddr;
  logic [2*SW-1:0] mwdata, mrdata;
  logic [2*SW-1:0] mem [N];
  logic [2*SW-1:0] rbuf;
  int rcnt;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  trig_capture #(.AW(AW), .SW(SW), .TW(32)) i_trig_capture (
    .clk(clk), .rst_n(rst_n), .pps_i(pps), .adc_x_i(ax), .adc_y_i(ay),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mem_req_o(req), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdy_i(rdy), .mem_rvalid_i(rvalid), .mem_rdata_i(mrdata)
  );

  // behavioural memory, read latency two clocks
  always_ff @(posedge clk) begin
    if (req && mwe && rdy) mem[maddr] <= mwdata;
    if (req && !mwe && rdy) begin
      rcnt <= 2;
      rbuf <= mem[maddr];
    end else if (rcnt != 0) rcnt <= rcnt - 1;
  end
  assign rvalid = (rcnt == 1);
  assign mrdata = rbuf;

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic pulse;
    pps = 1'b1;
    @(negedge clk);
    pps = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    d = '0;
    for (int t = 0; t < 12 && !d[31]; t++) rd(3'd4, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int nwr;
    rcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 req", {31'b0, req}, 32'd0);
    rd(3'd3, d); check("R1 status", d, 32'd0);

    // R2 seconds load and count
    wr(3'd2, 32'd5);
    pulse; pulse; pulse;
    repeat (2) @(negedge clk);
    rd(3'd2, d); check("R2 seconds", d, 32'd8);

    // R11 readback of trigger register
    wr(3'd1, 32'd10);
    rd(3'd1, d); check("R11 trig readback", d, 32'd10);

    // R3 arm with test pattern, trigger timing
    wr(3'd0, 32'h5);
    rd(3'd3, d); check("R3 armed", {29'b0, d[2:0]}, 32'd1);
    pulse;
    rd(3'd3, d); check("R3 still armed at 9", {29'b0, d[2:0]}, 32'd1);
    pps = 1'b1;
    @(negedge clk);
    pps = 1'b0;
    check("R3 no req on match edge", {31'b0, req}, 32'd0);
    @(negedge clk);
    check("R3 req one clock later", {31'b0, req}, 32'd1);
    check("R4 first address", {28'b0, maddr}, 32'd0);
    nwr = 0;
    for (int c = 0; c < 30; c++) begin
      if (req && mwe) nwr++;
      @(negedge clk);
    end
    check("R4 write count", nwr, N);
    rd(3'd3, d);
    check("R4 full state", {29'b0, d[2:0]}, 32'd3);
    check("R4 word count", {16'b0, d[31:16]}, N);
    check("R7 no overflow", {31'b0, d[3]}, 32'd0);
    for (int k = 0; k < N; k++)
      check("R4 sequential address", {20'b0, mem[k][11:0]}, k);

    // R10 arm refused in FULL
    wr(3'd0, 32'h1);
    rd(3'd3, d); check("R10 full kept", {29'b0, d[2:0]}, 32'd3);

    // R8 readout, R6 pattern values, R5 packing
    wr(3'd0, 32'h8);
    rd(3'd3, d); check("R8 readout state", {29'b0, d[2:0]}, 32'd4);
    for (int k = 0; k < N; k++) begin
      pop(d);
      check("R8 word available", {31'b0, d[31]}, 32'd1);
      check("R6 pattern X", {20'b0, d[11:0]}, k % 4096);
      check("R6 pattern Y", {20'b0, d[23:12]}, (k + 2048) % 4096);
    end
    rd(3'd3, d); check("R8 back to idle", {29'b0, d[2:0]}, 32'd0);

    // R5/R6 live converter data
    ax = 12'hABC; ay = 12'h123;
    wr(3'd2, 32'd0);
    wr(3'd1, 32'd1);
    wr(3'd0, 32'h1);
    pulse;
    repeat (30) @(negedge clk);
    rd(3'd3, d); check("R4 full live", {29'b0, d[2:0]}, 32'd3);
    wr(3'd0, 32'h8);
    for (int k = 0; k < N; k++) begin
      pop(d);
      check("R5 packed live word", d, 32'h80123ABC);
    end

    // R7 overflow with dropped samples
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h5);
    pulse;
    while (!req) @(negedge clk);
    for (int c = 0; c < N + 3; c++) begin
      rdy = !(c >= 5 && c < 8);
      @(negedge clk);
    end
    rdy = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd3, d);
    check("R7 full after loss", {29'b0, d[2:0]}, 32'd3);
    check("R7 overflow set", {31'b0, d[3]}, 32'd1);
    check("R7 count", {16'b0, d[31:16]}, N);
    rd(3'd5, d); check("R7 loss index", d, 32'd5);
    wr(3'd0, 32'h8);
    for (int k = 0; k < 8; k++) begin
      pop(d);
      check("R7 stored X after gap", {20'b0, d[11:0]}, (k < 5) ? k : k + 3);
    end

    // R10 arm refused in READOUT
    wr(3'd0, 32'h1);
    rd(3'd3, d); check("R10 readout kept", {29'b0, d[2:0]}, 32'd4);

    // R9 clear from READOUT and from ARMED
    wr(3'd0, 32'h2);
    rd(3'd3, d); check("R9 clear from readout", d, 32'd0);
    wr(3'd1, 32'd100);
    wr(3'd0, 32'h1);
    rd(3'd3, d); check("R9 rearm after clear", {29'b0, d[2:0]}, 32'd1);
    wr(3'd0, 32'h2);
    rd(3'd3, d); check("R9 clear from armed", d, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule